// File: doc/BRIEF.md
# Ethernet MII Receive Frame Filter

This block sits behind the 4-bit receive side of a media-independent interface and turns the nibble stream into frames for a receive FIFO. The block runs on the receive clock. It locks onto the preamble and the start delimiter, builds bytes from the nibbles with the low nibble first, and keeps a running CRC-32 over the whole frame. It counts the frame length and classifies the destination address against the station address. Frames that pass the address filter go byte by byte to a FIFO write port. The port marks the first and last byte, and the last byte carries a status word.

Six bytes are held back in a short delay line, because the address decision is known only after the sixth byte. When the data-valid line drops, the held bytes drain at one byte per clock. The last of them carries the CRC, length, symbol-error and match-type result. In parallel, a wake detector scans every received byte for a wake-up pattern addressed to this station. It raises a one-cycle pulse when wake detection is enabled.

Top module: `mii_rx_filter`

## Requirements
- R1: While reset is held and after its release with no input activity, `fifo_wr`, `fifo_sof`, `fifo_eof`, `fifo_status` and `wake_pulse` are all low.
- R2: Nibbles are paired low nibble first into bytes. Nibble 0x5 repeated, then nibble 0xD, starts a frame, and these preamble and delimiter bytes are never written. The first written byte of a frame is the first destination byte and carries `fifo_sof`.
- R3: Every byte of an accepted frame, including the four FCS bytes, is written once and in arrival order. The last byte carries `fifo_eof` and the status. `fifo_status` is zero on every other write, and `fifo_sof`/`fifo_eof` are only ever high together with `fifo_wr`.
- R4: The CRC-32 (polynomial 0x04C11DB7, reflected, preset to all ones) run over the whole frame including its FCS must leave the standard residue. Otherwise status bit 4 (CRC error) is set.
- R5: A frame shorter than 64 or longer than 1518 bytes (FCS included) sets status bit 3 (length error). Lengths 64 and 1518 do not.
- R6: `mii_er` high on any nibble inside the frame sets status bit 2 (symbol error), and the frame is still written.
- R7: Status bits [1:0] give the match type: 2'b11 when the destination is all ones, 2'b10 when bit 0 of the first destination byte is 1 and the destination is not broadcast, 2'b01 when the destination equals `station_addr` (first byte = bits [47:40]). A frame with none of these produces no write at all.
- R8: Any nibble other than 0x5 or 0xD during the preamble discards the whole frame with no writes.
- R9: Six 0xFF bytes followed by sixteen back-to-back copies of `station_addr` anywhere in the frame raise `wake_pulse` for exactly one cycle, at most once per frame, and only while `wake_en` is high. Fifteen copies raise nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mii_rxd | input | 4 | Receive nibble |
| mii_dv | input | 1 | Receive data valid |
| mii_er | input | 1 | Receive symbol error |
| station_addr | input | 48 | Own MAC address, first byte in [47:40] |
| wake_en | input | 1 | Enables the wake pulse |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_data | output | 8 | FIFO write byte |
| fifo_sof | output | 1 | First byte of frame |
| fifo_eof | output | 1 | Last byte of frame |
| fifo_status | output | 5 | {crc_err, len_err, sym_err, match[1:0]}, valid on the last byte |
| wake_pulse | output | 1 | One-cycle wake detection pulse |

## Verification
The hardest case to reach is the end of a frame that has crossed the address filter. There, the byte still arriving, the six held-back bytes and the final status all meet during the drain. An error must show on exactly one write, and that write must also carry the end mark. The bench builds whole frames with a correct FCS and then changes a single thing in each: a flipped payload bit, a nibble with `mii_er`, a length one byte past either limit, or a corrupted preamble nibble. A queue model then predicts every write, its flags and its status. Wake-up frames are sent with sixteen and with fifteen address copies, and with the enable both set and cleared.

// File: rtl/mii_rx_pkg.sv
package mii_rx_pkg;

    localparam int ADDR_BYTES = 6;
    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
    localparam logic [31:0] CRC_RESIDUE   = 32'hDEBB20E3;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_PRE,
        RX_DATA,
        RX_DROP,
        RX_FLUSH
    } rx_state_e;

    typedef enum logic [1:0] {
        MATCH_NONE  = 2'b00,
        MATCH_OWN   = 2'b01,
        MATCH_MULTI = 2'b10,
        MATCH_BCAST = 2'b11
    } match_e;

    typedef struct packed {
        logic   crc_err;
        logic   len_err;
        logic   sym_err;
        match_e kind;
    } rx_status_t;

    // advance a reflected CRC-32 by one nibble, least significant bit first
    function automatic logic [31:0] crc_step_nib(logic [31:0] crc, logic [3:0] nib);
        logic [31:0] c;
        c = crc;
        for (int i = 0; i < 4; i++) begin
            if (c[0] ^ nib[i]) c = (c >> 1) ^ CRC_POLY_REFL;
            else               c = c >> 1;
        end
        return c;
    endfunction

endpackage

// File: rtl/mii_rx_crc32.sv
module mii_rx_crc32
    import mii_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       init,
    input  logic       nib_vld,
    input  logic [3:0] nib,
    output logic       crc_ok
);

    logic [31:0] crc_d, crc_q;

    always_comb begin
        crc_d = crc_q;
        if (init)         crc_d = '1;
        else if (nib_vld) crc_d = crc_step_nib(crc_q, nib);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= '1;
        else        crc_q <= crc_d;
    end

    assign crc_ok = (crc_q == CRC_RESIDUE);

endmodule

// File: rtl/mii_rx_addr_filter.sv
module mii_rx_addr_filter
    import mii_rx_pkg::*;
(
    input  logic [47:0] dest,
    input  logic [47:0] station,
    output match_e      kind
);

    always_comb begin
        if (&dest)                kind = MATCH_BCAST;
        else if (dest[40])        kind = MATCH_MULTI;
        else if (dest == station) kind = MATCH_OWN;
        else                      kind = MATCH_NONE;
    end

endmodule

// File: rtl/mii_rx_magic.sv
module mii_rx_magic
    import mii_rx_pkg::*;
#(
    parameter int SYNC_BYTES = 6,
    parameter int REPEATS    = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        enable,
    input  logic        byte_vld,
    input  logic [7:0]  byte_in,
    input  logic [47:0] station,
    output logic        hit
);

    localparam int FF_W  = $clog2(SYNC_BYTES + 1);
    localparam int REP_W = (REPEATS > 1) ? $clog2(REPEATS) : 1;

    typedef struct packed {
        logic [FF_W-1:0]  ff_cnt;
        logic             matching;
        logic [2:0]       pos;
        logic [REP_W-1:0] rep;
        logic             done;
        logic             hit;
    } magic_t;

    magic_t s_d, s_q;
    logic [7:0] expect_byte;

    always_comb begin
        expect_byte = station[47:40];
        for (int i = 0; i < ADDR_BYTES; i++) begin
            if (s_q.pos == 3'(i)) expect_byte = station[8*(ADDR_BYTES-1-i) +: 8];
        end
    end

    always_comb begin
        s_d     = s_q;
        s_d.hit = 1'b0;
        if (clr) begin
            s_d = '0;
        end else if (byte_vld && !s_q.done) begin
            if (s_q.matching) begin
                if (byte_in == expect_byte) begin
                    if (s_q.pos == 3'(ADDR_BYTES - 1)) begin
                        s_d.pos = '0;
                        if (s_q.rep == REP_W'(REPEATS - 1)) begin
                            s_d.done     = 1'b1;
                            s_d.matching = 1'b0;
                            s_d.hit      = enable;
                        end else begin
                            s_d.rep = s_q.rep + 1'b1;
                        end
                    end else begin
                        s_d.pos = s_q.pos + 1'b1;
                    end
                end else begin
                    s_d.matching = 1'b0;
                    s_d.pos      = '0;
                    s_d.rep      = '0;
                    s_d.ff_cnt   = (byte_in == 8'hFF) ? FF_W'(1) : '0;
                end
            end else if (byte_in == 8'hFF) begin
                if (s_q.ff_cnt != FF_W'(SYNC_BYTES)) s_d.ff_cnt = s_q.ff_cnt + 1'b1;
            end else if (s_q.ff_cnt == FF_W'(SYNC_BYTES) && byte_in == station[47:40]) begin
                s_d.matching = 1'b1;
                s_d.pos      = 3'd1;
                s_d.rep      = '0;
                s_d.ff_cnt   = '0;
            end else begin
                s_d.ff_cnt = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign hit = s_q.hit;

endmodule

// File: rtl/mii_rx_filter.sv
module mii_rx_filter
    import mii_rx_pkg::*;
#(
    parameter int MIN_LEN     = 64,
    parameter int MAX_LEN     = 1518,
    parameter int WAKE_SYNC   = 6,
    parameter int WAKE_COPIES = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  mii_rxd,
    input  logic        mii_dv,
    input  logic        mii_er,
    input  logic [47:0] station_addr,
    input  logic        wake_en,
    output logic        fifo_wr,
    output logic [7:0]  fifo_data,
    output logic        fifo_sof,
    output logic        fifo_eof,
    output logic [4:0]  fifo_status,
    output logic        wake_pulse
);

    localparam int LEN_W = $clog2(MAX_LEN + 2);
    localparam int CNT_W = $clog2(ADDR_BYTES + 1);
    localparam logic [LEN_W-1:0] LEN_CAP = LEN_W'(MAX_LEN + 1);

    typedef struct packed {
        rx_state_e                      st;
        logic [3:0]                     lo_nib;
        logic                           phase;
        logic [LEN_W-1:0]               len;
        logic [ADDR_BYTES-1:0][7:0]     dly;
        logic [CNT_W-1:0]               dly_cnt;
        logic                           accept;
        match_e                         kind;
        logic                           sof_pend;
        logic                           sym_err;
        rx_status_t                     status;
        logic                           wr;
        logic [7:0]                     data;
        logic                           sof;
        logic                           eof;
        rx_status_t                     stat_out;
    } rx_t;

    rx_t s_d, s_q;

    logic        crc_init, nib_vld, crc_ok;
    logic        byte_vld, magic_clr;
    logic [7:0]  byte_now;
    logic [47:0] dest;
    match_e      dest_kind;

    assign byte_now = {mii_rxd, s_q.lo_nib};

    always_comb begin
        for (int i = 0; i < ADDR_BYTES - 1; i++) begin
            dest[8*(ADDR_BYTES-1-i) +: 8] = s_q.dly[i];
        end
        dest[7:0] = byte_now;
    end

    mii_rx_addr_filter u_filter (
        .dest    (dest),
        .station (station_addr),
        .kind    (dest_kind)
    );

    mii_rx_crc32 u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .init    (crc_init),
        .nib_vld (nib_vld),
        .nib     (mii_rxd),
        .crc_ok  (crc_ok)
    );

    mii_rx_magic #(
        .SYNC_BYTES (WAKE_SYNC),
        .REPEATS    (WAKE_COPIES)
    ) u_magic (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (magic_clr),
        .enable   (wake_en),
        .byte_vld (byte_vld),
        .byte_in  (byte_now),
        .station  (station_addr),
        .hit      (wake_pulse)
    );

    always_comb begin
        s_d          = s_q;
        s_d.wr       = 1'b0;
        s_d.sof      = 1'b0;
        s_d.eof      = 1'b0;
        s_d.stat_out = '0;
        crc_init     = 1'b0;
        nib_vld      = 1'b0;
        byte_vld     = 1'b0;
        magic_clr    = 1'b0;

        case (s_q.st)
            RX_IDLE: begin
                if (mii_dv && mii_rxd == 4'h5) s_d.st = RX_PRE;
            end
            RX_PRE: begin
                if (!mii_dv) begin
                    s_d.st = RX_IDLE;
                end else if (mii_rxd == 4'hD) begin
                    s_d.st       = RX_DATA;
                    s_d.phase    = 1'b0;
                    s_d.len      = '0;
                    s_d.dly_cnt  = '0;
                    s_d.accept   = 1'b0;
                    s_d.kind     = MATCH_NONE;
                    s_d.sof_pend = 1'b0;
                    s_d.sym_err  = 1'b0;
                    crc_init     = 1'b1;
                    magic_clr    = 1'b1;
                end else if (mii_rxd != 4'h5) begin
                    s_d.st = RX_DROP;
                end
            end
            RX_DATA: begin
                if (mii_dv) begin
                    nib_vld = 1'b1;
                    if (mii_er) s_d.sym_err = 1'b1;
                    if (!s_q.phase) begin
                        s_d.lo_nib = mii_rxd;
                        s_d.phase  = 1'b1;
                    end else begin
                        s_d.phase = 1'b0;
                        byte_vld  = 1'b1;
                        if (s_q.len != LEN_CAP) s_d.len = s_q.len + 1'b1;
                        if (s_q.dly_cnt == CNT_W'(ADDR_BYTES)) begin
                            if (s_q.accept) begin
                                s_d.wr       = 1'b1;
                                s_d.data     = s_q.dly[0];
                                s_d.sof      = s_q.sof_pend;
                                s_d.sof_pend = 1'b0;
                            end
                            for (int i = 0; i < ADDR_BYTES - 1; i++) s_d.dly[i] = s_q.dly[i+1];
                            s_d.dly[ADDR_BYTES-1] = byte_now;
                        end else begin
                            for (int i = 0; i < ADDR_BYTES; i++) begin
                                if (s_q.dly_cnt == CNT_W'(i)) s_d.dly[i] = byte_now;
                            end
                            s_d.dly_cnt = s_q.dly_cnt + 1'b1;
                            if (s_q.dly_cnt == CNT_W'(ADDR_BYTES - 1)) begin
                                s_d.kind     = dest_kind;
                                s_d.accept   = (dest_kind != MATCH_NONE);
                                s_d.sof_pend = (dest_kind != MATCH_NONE);
                            end
                        end
                    end
                end else begin
                    s_d.status.crc_err = !crc_ok;
                    s_d.status.len_err = (s_q.len < LEN_W'(MIN_LEN)) || (s_q.len > LEN_W'(MAX_LEN));
                    s_d.status.sym_err = s_q.sym_err;
                    s_d.status.kind    = s_q.kind;
                    s_d.st             = s_q.accept ? RX_FLUSH : RX_IDLE;
                end
            end
            RX_FLUSH: begin
                s_d.wr       = 1'b1;
                s_d.data     = s_q.dly[0];
                s_d.sof      = s_q.sof_pend;
                s_d.sof_pend = 1'b0;
                for (int i = 0; i < ADDR_BYTES - 1; i++) s_d.dly[i] = s_q.dly[i+1];
                s_d.dly[ADDR_BYTES-1] = '0;
                s_d.dly_cnt = s_q.dly_cnt - 1'b1;
                if (s_q.dly_cnt == CNT_W'(1)) begin
                    s_d.eof      = 1'b1;
                    s_d.stat_out = s_q.status;
                    s_d.accept   = 1'b0;
                    s_d.st       = RX_IDLE;
                end
            end
            RX_DROP: begin
                if (!mii_dv) s_d.st = RX_IDLE;
            end
            default: s_d.st = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= RX_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign fifo_wr     = s_q.wr;
    assign fifo_data   = s_q.data;
    assign fifo_sof    = s_q.sof;
    assign fifo_eof    = s_q.eof;
    assign fifo_status = s_q.stat_out;

endmodule

// File: rtl/mii_rx_filter_chk.sv
module mii_rx_filter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       fifo_wr,
    input logic       fifo_sof,
    input logic       fifo_eof,
    input logic [4:0] fifo_status,
    input logic       wake_en,
    input logic       wake_pulse
);

    // R3
    marks_need_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_sof || fifo_eof) |-> fifo_wr);

    // R3
    status_on_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_status != 5'd0) |-> fifo_eof);

    // R7
    last_has_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_eof |-> (fifo_status[1:0] != 2'b00));

    // R9
    wake_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |=> !wake_pulse);

    // R9
    wake_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> $past(wake_en));

endmodule

bind mii_rx_filter mii_rx_filter_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fifo_wr     (fifo_wr),
    .fifo_sof    (fifo_sof),
    .fifo_eof    (fifo_eof),
    .fifo_status (fifo_status),
    .wake_en     (wake_en),
    .wake_pulse  (wake_pulse)
);

// File: tb/test_mii_rx_filter.sv
module test_mii_rx_filter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  mii_rxd = '0;
    logic        mii_dv = 1'b0;
    logic        mii_er = 1'b0;
    logic [47:0] station_addr = 48'h02A0B1C2D3E4;
    logic        wake_en = 1'b0;
    logic        fifo_wr, fifo_sof, fifo_eof, wake_pulse;
    logic [7:0]  fifo_data;
    logic [4:0]  fifo_status;

    always #2 clk = ~clk;

    mii_rx_filter i_mii_rx_filter (
        .clk(clk), .rst_n(rst_n), .mii_rxd(mii_rxd), .mii_dv(mii_dv), .mii_er(mii_er),
        .station_addr(station_addr), .wake_en(wake_en), .fifo_wr(fifo_wr),
        .fifo_data(fifo_data), .fifo_sof(fifo_sof), .fifo_eof(fifo_eof),
        .fifo_status(fifo_status), .wake_pulse(wake_pulse)
    );

    int checks = 0;
    int fails  = 0;
    int wake_seen = 0;
    int wake_exp  = 0;
    string cur_req = "R1";
    logic [7:0]  frame_q[$];
    logic [14:0] exp_q[$];   // {sof, eof, status[4:0], data[7:0]}

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // reference model comparison every clock, away from the edge
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            if (wake_pulse) wake_seen++;
            if (fifo_wr) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, cur_req, "unexpected write", {17'd0, fifo_sof, fifo_eof, fifo_status, fifo_data}, 0);
                end else begin
                    logic [14:0] e;
                    e = exp_q.pop_front();
                    check({fifo_sof, fifo_eof, fifo_status, fifo_data} == e, cur_req, "write",
                          {17'd0, fifo_sof, fifo_eof, fifo_status, fifo_data}, {17'd0, e});
                end
            end else if (fifo_sof || fifo_eof) begin
                check(1'b0, "R3", "mark without write", {30'd0, fifo_sof, fifo_eof}, 0);
            end
        end
    end

    function automatic logic [31:0] fcs_calc();
        logic [31:0] c = 32'hFFFFFFFF;
        foreach (frame_q[i]) begin
            logic [7:0] b = frame_q[i];
            for (int k = 0; k < 8; k++) begin
                c = ((c[0] ^ b[k]) != 1'b0) ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
            end
        end
        return ~c;
    endfunction

    task automatic build(input logic [47:0] dest, input int total, input int copies);
        logic [31:0] f;
        frame_q.delete();
        for (int i = 5; i >= 0; i--) frame_q.push_back(dest[8*i +: 8]);
        for (int i = 0; i < 6; i++) frame_q.push_back(8'h10 + 8'(i));
        frame_q.push_back(8'h08);
        frame_q.push_back(8'h00);
        if (copies > 0) begin
            for (int i = 0; i < 6; i++) frame_q.push_back(8'hFF);
            for (int c = 0; c < copies; c++)
                for (int i = 5; i >= 0; i--) frame_q.push_back(station_addr[8*i +: 8]);
        end
        while (frame_q.size() < total - 4) frame_q.push_back(8'((frame_q.size() * 3) & 8'h7F));
        f = fcs_calc();
        for (int i = 0; i < 4; i++) frame_q.push_back(f[8*i +: 8]);
    endtask

    task automatic expect_frame(input bit crc_e, input bit len_e, input bit sym_e);
        logic [47:0] d;
        logic [1:0]  kind;
        for (int i = 0; i < 6; i++) d[8*(5-i) +: 8] = frame_q[i];
        if (&d)                    kind = 2'b11;
        else if (d[40])            kind = 2'b10;
        else if (d == station_addr) kind = 2'b01;
        else                       kind = 2'b00;
        if (kind != 2'b00) begin
            foreach (frame_q[i]) begin
                bit last = (i == frame_q.size() - 1);
                exp_q.push_back({(i == 0), last, last ? {crc_e, len_e, sym_e, kind} : 5'd0, frame_q[i]});
            end
        end
    endtask

    task automatic send(input int er_idx, input bit bad_pre);
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            mii_dv  = 1'b1;
            mii_er  = 1'b0;
            mii_rxd = (i == 15) ? 4'hD : ((bad_pre && i == 6) ? 4'hA : 4'h5);
        end
        foreach (frame_q[i]) begin
            @(negedge clk); mii_rxd = frame_q[i][3:0]; mii_er = (i == er_idx);
            @(negedge clk); mii_rxd = frame_q[i][7:4]; mii_er = 1'b0;
        end
        @(negedge clk);
        mii_dv = 1'b0; mii_er = 1'b0; mii_rxd = '0;
        repeat (30) @(negedge clk);
        check(exp_q.size() == 0, cur_req, "pending writes", exp_q.size(), 0);
        exp_q.delete();
        check(wake_seen == wake_exp, cur_req, "wake count", wake_seen, wake_exp);
    endtask

    initial begin
        #(4 * 200000);
        check(1'b0, "WDOG", "watchdog", 0, 1);
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check({fifo_wr, fifo_sof, fifo_eof, wake_pulse, fifo_status} == 0, "R1", "in reset", {fifo_wr, fifo_sof, fifo_eof, wake_pulse, fifo_status}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check({fifo_wr, fifo_sof, fifo_eof, wake_pulse, fifo_status} == 0, "R1", "after reset", {fifo_wr, fifo_sof, fifo_eof, wake_pulse, fifo_status}, 0);

        // R2 R3 own unicast, minimum legal length
        cur_req = "R2"; build(station_addr, 64, 0); expect_frame(0, 0, 0); send(-1, 0);
        // R7 broadcast
        cur_req = "R7"; build(48'hFFFFFFFFFFFF, 70, 0); expect_frame(0, 0, 0); send(-1, 0);
        // R7 multicast
        cur_req = "R7"; build(48'h01005E000001, 64, 0); expect_frame(0, 0, 0); send(-1, 0);
        // R7 foreign unicast: nothing written
        cur_req = "R7"; build(48'h021122334455, 64, 0); expect_frame(0, 0, 0); send(-1, 0);
        // R4 corrupted payload bit
        cur_req = "R4"; build(station_addr, 80, 0); frame_q[20] ^= 8'h01; expect_frame(1, 0, 0); send(-1, 0);
        // R5 too short, too long, largest legal
        cur_req = "R5"; build(station_addr, 63, 0); expect_frame(0, 1, 0); send(-1, 0);
        cur_req = "R5"; build(station_addr, 1519, 0); expect_frame(0, 1, 0); send(-1, 0);
        cur_req = "R5"; build(station_addr, 1518, 0); expect_frame(0, 0, 0); send(-1, 0);
        // R6 symbol error mid frame
        cur_req = "R6"; build(station_addr, 64, 0); expect_frame(0, 0, 1); send(30, 0);
        // R8 bad preamble nibble
        cur_req = "R8"; build(station_addr, 64, 0); send(-1, 1);
        // R9 wake frames
        cur_req = "R9"; wake_en = 1'b1; build(station_addr, 128, 16); expect_frame(0, 0, 0);
        wake_exp++; send(-1, 0);
        cur_req = "R9"; wake_en = 1'b0; build(station_addr, 128, 16); expect_frame(0, 0, 0); send(-1, 0);
        cur_req = "R9"; wake_en = 1'b1; build(station_addr, 128, 15); expect_frame(0, 0, 0); send(-1, 0);
        // R3 frame following back to back filter decisions still starts cleanly
        cur_req = "R3"; build(station_addr, 66, 0); expect_frame(0, 0, 0); send(-1, 0);

        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule